// File: doc/BRIEF.md
# NAND Page Transfer Sequencer

This block carries the data area of one flash page between a 32-bit DMA-facing word stream and an 8-bit byte stream that feeds the NAND strobe logic. It works in both directions. Software loads a byte count, chooses the direction in the config register and raises the start bit. Each byte that crosses the NAND side lowers the count by one. At zero the block stops requesting bytes and raises the transfer-count interrupt bit. A small word FIFO and a one-word byte lane sit between the two sides. A status register shows whether either of them still holds data.

The block also drives the ECC timing. It gives a one-cycle snapshot pulse after every `SNAP_BYTES` bytes, and a clear pulse when software asks for one. The ECC arithmetic itself lives outside. Completion and device-ready events are latched in a raw interrupt register. Software can set or clear each bit, and an enable mask selects which raw bits drive the single interrupt line.

All four streams are valid/ready. A byte or word moves on a clock edge where both valid and ready are high. A source holds valid and data steady until the transfer is accepted. The block applies back-pressure on `dma_in_ready` when its FIFO is full and on `nand_rx_ready` when its lane is full. It keeps `nand_tx_data` and `dma_out_data` steady while the other side stalls.

Register map (3-bit word address): 0 control, 1 config, 2 status, 3 count, 4 raw interrupt (read only), 5 interrupt enable, 6 interrupt set, 7 interrupt clear. Interrupt bit 1 is transfer done and bit 0 is device-ready rising. Addresses 6 and 7 read as zero.

Top module: `nand_page_seq`

## Requirements
- R1: After reset, config, count, status FIFO bits, raw interrupt and `irq` all read zero, and neither byte stream is active.
- R2: With config bit 1 at 0 (write), words accepted on `dma_in` leave on `nand_tx` least significant byte first. The count (address 3) drops by one in the cycle after each byte handshake.
- R3: With config bit 1 at 1 (read), bytes taken from `nand_rx` are packed least significant byte first into words on `dma_out`. A final partial word is sent with its missing upper bytes set to zero.
- R4: While the count is zero, `nand_tx_valid` and `nand_rx_ready` stay low. The byte that takes the count from 1 to 0 sets raw interrupt bit 1.
- R5: `dma_in_ready` is low while the FIFO is full. `nand_tx_data` and `dma_out_data` hold steady while their valid is high and ready is low.
- R6: `irq` is the OR of raw AND enable. Writing 1 to a bit at address 6 sets that raw bit, and writing 1 at address 7 clears it. A hardware event in the same cycle as a clear wins.
- R7: A low-to-high change of `nand_rdy` sets raw interrupt bit 0.
- R8: The status register (address 2) shows the word FIFO non-empty on bit 2, the byte lane non-empty on bit 1, and `nand_rdy` on bit 0.
- R9: `ecc_snap` pulses for one cycle after every `SNAP_BYTES`-th byte, counted since the last count load or clear, and only when config bits 3 and 4 are both set. Writing control bit 1 pulses `ecc_clear` and restarts that byte phase.
- R10: Writing control bit 2 zeroes config, interrupt enable, count and the start bit, and empties the FIFO and the lane. Raw interrupt bits are kept.
- R11: With the start bit (control bit 0) low, no byte moves on either NAND stream and `dma_in_ready` stays low.
- R12: Config bits 5..0 read back as written. Bit 5 drives `chip_en_low` and bit 2 drives `dma_burst`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 3 | Register word address |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on address) |
| dma_in_valid | input | 1 | Word offered from DMA (write direction) |
| dma_in_ready | output | 1 | Block accepts the DMA word |
| dma_in_data | input | DW | DMA word |
| dma_out_valid | output | 1 | Word offered to DMA (read direction) |
| dma_out_ready | input | 1 | DMA accepts the word |
| dma_out_data | output | DW | Word toward DMA |
| dma_burst | output | 1 | Burst-request mode from config |
| nand_tx_valid | output | 1 | Byte offered toward NAND |
| nand_tx_ready | input | 1 | NAND strobe logic takes the byte |
| nand_tx_data | output | 8 | Byte toward NAND |
| nand_rx_valid | input | 1 | Byte offered from NAND |
| nand_rx_ready | output | 1 | Block takes the NAND byte |
| nand_rx_data | input | 8 | Byte from NAND |
| nand_rdy | input | 1 | Device ready level |
| chip_en_low | output | 1 | Force chip enable active |
| ecc_clear | output | 1 | One-cycle pulse that clears the ECC accumulator |
| ecc_snap | output | 1 | One-cycle pulse to capture the ECC at a block boundary |
| irq | output | 1 | Interrupt line |

## Verification
The bench uses a two-word FIFO, a 12-bit count and an 8-byte ECC block. With the NAND side stalled, the FIFO fills after three words, so back-pressure on the DMA input shows within a few cycles. A 20-byte page crosses two snapshot boundaries and needs five full words. A 10-byte read ends on a partial word, which checks the zero padding. The small count keeps each transfer short while the decrement-to-zero path is still exercised in both directions.

// File: rtl/nps_pkg.sv
package nps_pkg;
  localparam logic [2:0] A_CTRL = 3'd0;
  localparam logic [2:0] A_CFG  = 3'd1;
  localparam logic [2:0] A_STAT = 3'd2;
  localparam logic [2:0] A_CNT  = 3'd3;
  localparam logic [2:0] A_RAW  = 3'd4;
  localparam logic [2:0] A_EN   = 3'd5;
  localparam logic [2:0] A_SET  = 3'd6;
  localparam logic [2:0] A_CLR  = 3'd7;

  localparam int CTRL_GO   = 0;
  localparam int CTRL_ECLR = 1;
  localparam int CTRL_SRST = 2;

  localparam int CFG_WIDE  = 0;
  localparam int CFG_DIR   = 1;
  localparam int CFG_BURST = 2;
  localparam int CFG_ECC   = 3;
  localparam int CFG_DECC  = 4;
  localparam int CFG_CE    = 5;
  localparam int CFG_W     = 6;

  localparam int IRQ_RDY = 0;
  localparam int IRQ_TC  = 1;
  localparam int IRQ_N   = 2;
endpackage

// File: rtl/nps_fifo.sv
module nps_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         full,
  output logic         empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = AW + 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;

  assign full  = (cnt == CW'(DEPTH));
  assign empty = (cnt == '0);
  assign dout  = mem[rp];

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; cnt <= '0;
    end else if (flush) begin
      wp <= '0; rp <= '0; cnt <= '0;
    end else begin
      if (push) wp <= nxt(wp);
      if (pop)  rp <= nxt(rp);
      cnt <= cnt + CW'(push) - CW'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (push && !flush) mem[wp] <= din;
  end

  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !push);
  assert_no_underflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> !pop);
endmodule

// File: rtl/nps_lane.sv
module nps_lane #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          dir_rd,
  input  logic          run,
  input  logic          cnt_zero,
  input  logic [DW-1:0] fifo_dout,
  input  logic          fifo_empty,
  input  logic          fifo_full,
  output logic          fifo_pop,
  output logic          fifo_push,
  output logic [DW-1:0] pack_word,
  output logic          tx_valid,
  input  logic          tx_ready,
  output logic [7:0]    tx_data,
  input  logic          rx_valid,
  output logic          rx_ready,
  input  logic [7:0]    rx_data,
  output logic          byte_xfer,
  output logic          busy
);
  localparam int NB  = DW / 8;
  localparam int NBW = $clog2(NB) + 1;

  logic [DW-1:0]  word;
  logic [NBW-1:0] nb;
  logic           tx_hs, rx_hs;

  assign busy      = (nb != '0);
  assign tx_valid  = !dir_rd && run && !cnt_zero && busy;
  assign tx_data   = word[7:0];
  assign rx_ready  = dir_rd && run && !cnt_zero && (nb != NBW'(NB));
  assign tx_hs     = tx_valid && tx_ready;
  assign rx_hs     = rx_valid && rx_ready;
  assign byte_xfer = tx_hs || rx_hs;
  assign fifo_pop  = !dir_rd && run && !busy && !fifo_empty;
  assign fifo_push = dir_rd && busy && !fifo_full && ((nb == NBW'(NB)) || cnt_zero);
  assign pack_word = word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word <= '0; nb <= '0;
    end else if (flush) begin
      word <= '0; nb <= '0;
    end else if (fifo_pop) begin
      word <= fifo_dout; nb <= NBW'(NB);
    end else if (tx_hs) begin
      word <= word >> 8; nb <= nb - NBW'(1);
    end else if (rx_hs) begin
      word[8*nb[NBW-2:0] +: 8] <= rx_data; nb <= nb + NBW'(1);
    end else if (fifo_push) begin
      word <= '0; nb <= '0;
    end
  end
endmodule

// File: rtl/nps_irq.sv
module nps_irq #(
  parameter int NI = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          srst,
  input  logic [NI-1:0] hw_evt,
  input  logic          wr_en,
  input  logic          wr_set,
  input  logic          wr_clr,
  input  logic [NI-1:0] wdata,
  output logic [NI-1:0] raw,
  output logic [NI-1:0] en,
  output logic          irq
);
  logic [NI-1:0] set_m, clr_m;

  assign set_m = wr_set ? wdata : '0;
  assign clr_m = wr_clr ? wdata : '0;
  assign irq   = |(raw & en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw <= '0; en <= '0;
    end else begin
      raw <= (raw & ~clr_m) | set_m | hw_evt;
      if (srst)       en <= '0;
      else if (wr_en) en <= wdata;
    end
  end

  for (genvar i = 0; i < NI; i++) begin : g_chk
    assert_clr_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_clr && wdata[i] && !hw_evt[i]) |=> !raw[i]);
    assert_hw_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
      hw_evt[i] |=> raw[i]);
  end
endmodule

// File: rtl/nand_page_seq.sv
module nand_page_seq
  import nps_pkg::*;
#(
  parameter int DW         = 32,
  parameter int FIFO_DEPTH = 4,
  parameter int CNT_W      = 16,
  parameter int SNAP_BYTES = 256
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    reg_addr,
  input  logic          reg_wr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  input  logic          dma_in_valid,
  output logic          dma_in_ready,
  input  logic [DW-1:0] dma_in_data,
  output logic          dma_out_valid,
  input  logic          dma_out_ready,
  output logic [DW-1:0] dma_out_data,
  output logic          dma_burst,
  output logic          nand_tx_valid,
  input  logic          nand_tx_ready,
  output logic [7:0]    nand_tx_data,
  input  logic          nand_rx_valid,
  output logic          nand_rx_ready,
  input  logic [7:0]    nand_rx_data,
  input  logic          nand_rdy,
  output logic          chip_en_low,
  output logic          ecc_clear,
  output logic          ecc_snap,
  output logic          irq
);
  localparam int SPW = (SNAP_BYTES > 1) ? $clog2(SNAP_BYTES) : 1;

  logic              go, rdy_q, ecc_clear_q, ecc_snap_q;
  logic [CFG_W-1:0]  cfg;
  logic [CNT_W-1:0]  cnt;
  logic [SPW-1:0]    snap_ph;
  logic              wr_ctrl, wr_cfg, wr_cnt, srst, eclr, dir_rd, cnt_zero;
  logic              fifo_push, fifo_pop, fifo_full, fifo_empty;
  logic              lane_pop, lane_push, lane_busy, byte_xfer;
  logic [DW-1:0]     fifo_din, fifo_dout, pack_word;
  logic [IRQ_N-1:0]  hw_evt, irq_raw, irq_en;
  logic              unused_wdata;

  assign unused_wdata = ^reg_wdata;
  assign wr_ctrl  = reg_wr && (reg_addr == A_CTRL);
  assign wr_cfg   = reg_wr && (reg_addr == A_CFG);
  assign wr_cnt   = reg_wr && (reg_addr == A_CNT);
  assign srst     = wr_ctrl && reg_wdata[CTRL_SRST];
  assign eclr     = wr_ctrl && reg_wdata[CTRL_ECLR];
  assign dir_rd   = cfg[CFG_DIR];
  assign cnt_zero = (cnt == '0);

  assign chip_en_low = cfg[CFG_CE];
  assign dma_burst   = cfg[CFG_BURST];
  assign ecc_clear   = ecc_clear_q;
  assign ecc_snap    = ecc_snap_q;

  // control, config, count and ECC phase
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      go <= 1'b0; cfg <= '0; cnt <= '0; snap_ph <= '0;
      rdy_q <= 1'b0; ecc_clear_q <= 1'b0; ecc_snap_q <= 1'b0;
    end else begin
      rdy_q       <= nand_rdy;
      ecc_clear_q <= eclr;
      ecc_snap_q  <= byte_xfer && (snap_ph == SPW'(SNAP_BYTES - 1))
                     && cfg[CFG_ECC] && cfg[CFG_DECC];
      if (srst)         go <= 1'b0;
      else if (wr_ctrl) go <= reg_wdata[CTRL_GO];
      if (srst)        cfg <= '0;
      else if (wr_cfg) cfg <= reg_wdata[CFG_W-1:0];
      if (srst)           cnt <= '0;
      else if (wr_cnt)    cnt <= reg_wdata[CNT_W-1:0];
      else if (byte_xfer) cnt <= cnt - CNT_W'(1);
      if (srst || eclr || wr_cnt) snap_ph <= '0;
      else if (byte_xfer)
        snap_ph <= (snap_ph == SPW'(SNAP_BYTES - 1)) ? '0 : snap_ph + SPW'(1);
    end
  end

  // data path muxing by direction
  assign dma_in_ready  = !dir_rd && go && !fifo_full;
  assign dma_out_valid = dir_rd && !fifo_empty;
  assign dma_out_data  = fifo_dout;
  assign fifo_push     = dir_rd ? lane_push : (dma_in_valid && dma_in_ready);
  assign fifo_pop      = dir_rd ? (dma_out_valid && dma_out_ready) : lane_pop;
  assign fifo_din      = dir_rd ? pack_word : dma_in_data;

  nps_fifo #(.W(DW), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .flush(srst),
    .push(fifo_push), .din(fifo_din), .pop(fifo_pop), .dout(fifo_dout),
    .full(fifo_full), .empty(fifo_empty)
  );

  nps_lane #(.DW(DW)) u_lane (
    .clk(clk), .rst_n(rst_n), .flush(srst), .dir_rd(dir_rd), .run(go),
    .cnt_zero(cnt_zero), .fifo_dout(fifo_dout), .fifo_empty(fifo_empty),
    .fifo_full(fifo_full), .fifo_pop(lane_pop), .fifo_push(lane_push),
    .pack_word(pack_word), .tx_valid(nand_tx_valid), .tx_ready(nand_tx_ready),
    .tx_data(nand_tx_data), .rx_valid(nand_rx_valid), .rx_ready(nand_rx_ready),
    .rx_data(nand_rx_data), .byte_xfer(byte_xfer), .busy(lane_busy)
  );

  // interrupt events
  always_comb begin
    hw_evt          = '0;
    hw_evt[IRQ_TC]  = byte_xfer && (cnt == CNT_W'(1)) && !wr_cnt && !srst;
    hw_evt[IRQ_RDY] = nand_rdy && !rdy_q;
  end

  nps_irq #(.NI(IRQ_N)) u_irq (
    .clk(clk), .rst_n(rst_n), .srst(srst), .hw_evt(hw_evt),
    .wr_en(reg_wr && (reg_addr == A_EN)),
    .wr_set(reg_wr && (reg_addr == A_SET)),
    .wr_clr(reg_wr && (reg_addr == A_CLR)),
    .wdata(reg_wdata[IRQ_N-1:0]), .raw(irq_raw), .en(irq_en), .irq(irq)
  );

  // register read
  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CTRL: reg_rdata[CTRL_GO] = go;
      A_CFG:  reg_rdata[CFG_W-1:0] = cfg;
      A_STAT: reg_rdata[2:0] = {!fifo_empty, lane_busy, nand_rdy};
      A_CNT:  reg_rdata[CNT_W-1:0] = cnt;
      A_RAW:  reg_rdata[IRQ_N-1:0] = irq_raw;
      A_EN:   reg_rdata[IRQ_N-1:0] = irq_en;
      default: reg_rdata = '0;
    endcase
  end

  assert_zero_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_zero |-> (!nand_tx_valid && !nand_rx_ready));
  assert_tc_raise_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_xfer && cnt == CNT_W'(1) && !reg_wr) |=> irq_raw[IRQ_TC]);
  assert_tx_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (nand_tx_valid && !nand_tx_ready && !reg_wr) |=> (nand_tx_valid && $stable(nand_tx_data)));
  assert_out_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_out_valid && !dma_out_ready && !reg_wr) |=> (dma_out_valid && $stable(dma_out_data)));
  assert_halt_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !go |-> (!nand_tx_valid && !nand_rx_ready && !dma_in_ready));
  assert_snap_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!(cfg[CFG_ECC] && cfg[CFG_DECC]) && !reg_wr) |=> !ecc_snap);
endmodule

// File: tb/nand_page_seq_bench.sv
module nand_page_seq_bench;
  localparam int DEPTH = 2, CW = 12, SNAP = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [2:0]  reg_addr = 3'd3;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        dma_in_valid = 1'b0, dma_in_ready;
  logic [31:0] dma_in_data = '0;
  logic        dma_out_valid, dma_out_ready = 1'b0;
  logic [31:0] dma_out_data;
  logic        dma_burst, nand_tx_valid, nand_tx_ready = 1'b0;
  logic [7:0]  nand_tx_data;
  logic        nand_rx_valid = 1'b0, nand_rx_ready;
  logic [7:0]  nand_rx_data = '0;
  logic        nand_rdy = 1'b0, chip_en_low, ecc_clear, ecc_snap, irq;

  nand_page_seq #(.DW(32), .FIFO_DEPTH(DEPTH), .CNT_W(CW), .SNAP_BYTES(SNAP)) u_nand_page_seq (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .dma_in_valid(dma_in_valid), .dma_in_ready(dma_in_ready), .dma_in_data(dma_in_data),
    .dma_out_valid(dma_out_valid), .dma_out_ready(dma_out_ready), .dma_out_data(dma_out_data),
    .dma_burst(dma_burst), .nand_tx_valid(nand_tx_valid), .nand_tx_ready(nand_tx_ready),
    .nand_tx_data(nand_tx_data), .nand_rx_valid(nand_rx_valid), .nand_rx_ready(nand_rx_ready),
    .nand_rx_data(nand_rx_data), .nand_rdy(nand_rdy), .chip_en_low(chip_en_low),
    .ecc_clear(ecc_clear), .ecc_snap(ecc_snap), .irq(irq)
  );

  int total = 0, bad = 0, cyc = 0, snaps = 0, eclrs = 0;
  int m_cnt = 0, m_ph = 0;
  bit [1:0] m_raw = 0, m_en = 0;
  bit [5:0] m_cfg = 0;
  bit m_snap = 0, m_eclr = 0, m_prev_rdy = 0, hs_din = 0, hs_rx = 0, tx_stall = 0;
  logic [7:0]  exp_tx[$];
  logic [31:0] exp_out[$];
  logic [31:0] din_q[$];
  logic [7:0]  rx_q[$];

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // reference model, compared on every clock
  always @(negedge clk) if (rst_n) begin
    bit [1:0] ev, setm, clrm;
    logic [7:0] eb;
    logic [31:0] ew;
    cyc++;
    if (!reg_wr && reg_addr == 3'd3) chk(reg_rdata == m_cnt, "R2", "count", reg_rdata, m_cnt);
    chk(irq == |(m_raw & m_en), "R6", "irq", irq, |(m_raw & m_en));
    chk(ecc_snap == m_snap, "R9", "ecc_snap", ecc_snap, m_snap);
    chk(ecc_clear == m_eclr, "R9", "ecc_clear", ecc_clear, m_eclr);
    if (m_cnt == 0) chk(!nand_tx_valid && !nand_rx_ready, "R4", "quiet at zero",
                        {nand_tx_valid, nand_rx_ready}, 0);
    if (ecc_snap) snaps++;
    if (ecc_clear) eclrs++;
    m_snap = 0; m_eclr = 0; ev = 0; setm = 0; clrm = 0;
    hs_din = dma_in_valid && dma_in_ready;
    hs_rx  = nand_rx_valid && nand_rx_ready;
    if (nand_tx_valid && nand_tx_ready) begin
      eb = (exp_tx.size() > 0) ? exp_tx.pop_front() : 8'hxx;
      chk(nand_tx_data === eb, "R2", "tx byte", nand_tx_data, eb);
    end
    if (dma_out_valid && dma_out_ready) begin
      ew = (exp_out.size() > 0) ? exp_out.pop_front() : 32'hxxxxxxxx;
      chk(dma_out_data === ew, "R3", "out word", dma_out_data, ew);
    end
    if ((nand_tx_valid && nand_tx_ready) || hs_rx) begin
      if (m_ph == SNAP - 1 && m_cfg[4] && m_cfg[3]) m_snap = 1;
      m_ph = (m_ph + 1) % SNAP;
      m_cnt--;
      if (m_cnt == 0) ev[1] = 1;
    end
    if (nand_rdy && !m_prev_rdy) ev[0] = 1;
    m_prev_rdy = nand_rdy;
    if (reg_wr) begin
      case (reg_addr)
        3'd0: begin
          if (reg_wdata[1]) begin m_eclr = 1; m_ph = 0; end
          if (reg_wdata[2]) begin m_cfg = 0; m_en = 0; m_cnt = 0; m_ph = 0; end
        end
        3'd1: m_cfg = reg_wdata[5:0];
        3'd3: begin m_cnt = int'(reg_wdata[CW-1:0]); m_ph = 0; end
        3'd5: m_en = reg_wdata[1:0];
        3'd6: setm = reg_wdata[1:0];
        3'd7: clrm = reg_wdata[1:0];
        default: ;
      endcase
    end
    m_raw = (m_raw & ~clrm) | setm | ev;
  end

  // stream drivers
  always @(posedge clk) begin
    #1;
    if (hs_din && din_q.size() > 0) void'(din_q.pop_front());
    if (hs_rx && rx_q.size() > 0) void'(rx_q.pop_front());
    hs_din = 0;
    if (!(nand_rx_valid && !hs_rx)) begin
      nand_rx_valid = (rx_q.size() > 0) && (cyc % 5 != 3);
      nand_rx_data  = (rx_q.size() > 0) ? rx_q[0] : 8'h00;
    end
    hs_rx = 0;
    dma_in_valid  = din_q.size() > 0;
    dma_in_data   = (din_q.size() > 0) ? din_q[0] : 32'h0;
    nand_tx_ready = !tx_stall && (cyc % 3 != 1);
    dma_out_ready = (cyc % 4 != 2);
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    reg_addr = a; reg_wr = 1'b1; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 1'b0; reg_addr = 3'd3;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(posedge clk); #1;
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
    @(posedge clk); #1;
    reg_addr = 3'd3;
  endtask

  task automatic wait_zero();
    for (int n = 0; n < 2000 && m_cnt != 0; n++) @(negedge clk);
    repeat (4) @(posedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [7:0]  bytes[10];
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    rd(3'd1, v); chk(v == 0, "R1", "cfg after reset", v, 0);
    rd(3'd3, v); chk(v == 0, "R1", "count after reset", v, 0);
    rd(3'd2, v); chk(v == 0, "R1", "status after reset", v, 0);
    rd(3'd4, v); chk(v == 0, "R1", "raw after reset", v, 0);
    chk(!irq && !nand_tx_valid && !nand_rx_ready, "R1", "outputs idle",
        {irq, nand_tx_valid, nand_rx_ready}, 0);

    // R12 config bits
    wr(3'd1, 32'h3C);
    rd(3'd1, v); chk(v == 32'h3C, "R12", "cfg readback", v, 32'h3C);
    chk(chip_en_low && dma_burst, "R12", "ce/burst pins", {chip_en_low, dma_burst}, 3);

    // R2 write direction with back-pressure (R5, R8) and snapshots (R9)
    snaps = 0;
    wr(3'd5, 32'h2);
    wr(3'd3, 32'd20);
    tx_stall = 1;
    for (int i = 0; i < 5; i++) begin
      logic [31:0] w;
      w = 32'h11223344 + i * 32'h01020304;
      din_q.push_back(w);
      for (int b = 0; b < 4; b++) exp_tx.push_back(w[8*b +: 8]);
    end
    wr(3'd0, 32'h1);
    repeat (12) @(posedge clk);
    @(negedge clk);
    chk(!dma_in_ready, "R5", "dma_in_ready low when full", dma_in_ready, 0);
    rd(3'd2, v); chk(v == 32'h6, "R8", "status fifo+lane", v, 6);
    tx_stall = 0;
    wait_zero();
    chk(exp_tx.size() == 0, "R2", "all bytes out", exp_tx.size(), 0);
    chk(irq == 1'b1, "R4", "irq on done", irq, 1);
    rd(3'd4, v); chk(v[1] == 1'b1, "R4", "raw tc", v, 2);
    rd(3'd2, v); chk(v == 0, "R8", "status drained", v, 0);
    chk(snaps == 2, "R9", "snapshot count", snaps, 2);
    wr(3'd7, 32'h2);
    @(negedge clk); chk(!irq, "R6", "irq after clear", irq, 0);
    wr(3'd0, 32'h0);

    // R3 read direction, partial last word, no ECC
    snaps = 0;
    wr(3'd1, 32'h2);
    for (int i = 0; i < 10; i++) begin bytes[i] = 8'h5A ^ 8'(i * 37); rx_q.push_back(bytes[i]); end
    exp_out.push_back({bytes[3], bytes[2], bytes[1], bytes[0]});
    exp_out.push_back({bytes[7], bytes[6], bytes[5], bytes[4]});
    exp_out.push_back({16'h0, bytes[9], bytes[8]});
    wr(3'd3, 32'd10);
    wr(3'd0, 32'h1);
    wait_zero();
    for (int n = 0; n < 50 && exp_out.size() != 0; n++) @(negedge clk);
    chk(exp_out.size() == 0, "R3", "all words out", exp_out.size(), 0);
    chk(snaps == 0, "R9", "no snapshot when disabled", snaps, 0);
    rd(3'd2, v); chk(v == 0, "R8", "status after read", v, 0);
    wr(3'd7, 32'h2);
    wr(3'd0, 32'h0);

    // R11 halted: nothing moves
    wr(3'd1, 32'h0);
    wr(3'd3, 32'd8);
    din_q.push_back(32'hCAFEF00D); din_q.push_back(32'h0BADBEEF);
    repeat (8) @(posedge clk);
    @(negedge clk);
    chk(!dma_in_ready && !nand_tx_valid, "R11", "halted", {dma_in_ready, nand_tx_valid}, 0);
    rd(3'd2, v); chk(v == 0, "R11", "fifo untouched", v, 0);

    // R10 soft reset
    tx_stall = 1;
    wr(3'd5, 32'h3);
    wr(3'd6, 32'h1);
    wr(3'd0, 32'h1);
    repeat (6) @(posedge clk);
    rd(3'd2, v); chk(v == 32'h6, "R8", "status loaded", v, 6);
    wr(3'd0, 32'h4);
    din_q.delete();
    rd(3'd1, v); chk(v == 0, "R10", "cfg cleared", v, 0);
    rd(3'd5, v); chk(v == 0, "R10", "enable cleared", v, 0);
    rd(3'd3, v); chk(v == 0, "R10", "count cleared", v, 0);
    rd(3'd2, v); chk(v == 0, "R10", "fifos emptied", v, 0);
    rd(3'd4, v); chk(v == 1, "R10", "raw kept", v, 1);
    exp_tx.delete();
    tx_stall = 0;

    // R6 set/clear/enable
    wr(3'd5, 32'h1);
    @(negedge clk); chk(irq, "R6", "irq from set bit", irq, 1);
    wr(3'd7, 32'h1);
    rd(3'd4, v); chk(v == 0, "R6", "raw cleared", v, 0);
    wr(3'd6, 32'h2);
    @(negedge clk); chk(!irq, "R6", "masked bit", irq, 0);
    wr(3'd5, 32'h2);
    @(negedge clk); chk(irq, "R6", "unmasked bit", irq, 1);
    wr(3'd7, 32'h2);

    // R7 ready rising edge
    @(posedge clk); #1 nand_rdy = 1'b1;
    repeat (2) @(posedge clk);
    rd(3'd4, v); chk(v == 1, "R7", "raw ready", v, 1);
    rd(3'd2, v); chk(v == 1, "R8", "status ready", v, 1);
    wr(3'd7, 32'h1);

    // R9 ecc clear pulse
    eclrs = 0;
    wr(3'd0, 32'h2);
    repeat (2) @(posedge clk);
    chk(eclrs == 1, "R9", "ecc_clear pulse", eclrs, 1);

    repeat (3) @(posedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule